// File: doc/BRIEF.md
# Linked Page-Table Capture Walker

This block is a bus master that stores a stream of 32-bit capture words into memory pages. It finds those pages by walking a ring of table pages. Memory is addressed by page number plus a word index within the page. Word 0 of every table holds the page number of the next table. Each of the words 1 to `BUFS` holds the page number of one buffer page. The walker fills the buffers of a table one after another, filling each buffer from word 0 to its last word. It then follows the link to the next table. The last table points back to the first, so the walk never ends.

Software controls the walker through a small register write port. Register 5 holds the first table page number. Register 0 takes command words: start, stop, clear credits and add one credit. Pacing uses table credits. Each table the walker enters uses up one credit, and software returns a credit each time it has drained a table. The last word of every buffer page is always written nonzero, so software can poll that word to learn that the page is full. With the default sizes a page holds 1024 words and a table names 511 buffers.

Top module: `ptw_walker`

## Requirements
- R1: After reset, and at any time while idle, `mem_req` and `in_ready` are both low.
- R2: Once it holds a credit for a table, the walker reads word 0 of that table (the link). It then reads words 1 to `BUFS` in ascending order, and each value read is a buffer page number. Each buffer is written at word addresses `{page, index}` for index 0 to `PAGE_WORDS-1`, in ascending order, and the data comes from consecutive stream words.
- R3: After slot `BUFS` of a table is full, the walker moves on to the table named by that table's link. A ring of two tables therefore returns to the first table.
- R4: In the default marker mode, the last word of every buffer is written with bit `MARK_BIT` (default 31) forced to 1. All other words are written unchanged.
- R5: The walker enters a table, including the first one after a start, only while the credit count is nonzero, and entering uses up one credit. While the count is zero, the walker makes no memory request and accepts no stream word.
- R6: On register 0, the value 0x00000010 clears the credit count and 0x00000020 adds one credit, saturating at the maximum. Any other value has no effect. A write to register 5 sets the first table page number.
- R7: Writing 0x0c000040 to register 0 while idle starts a walk at the table in register 5. The same write has no effect while a walk is running.
- R8: Writing 0x08080000 to register 0 returns the walker to idle with no further memory write and no further accepted stream word. If a table read is waiting for its data, the stop takes effect once that data returns.
- R9: A stream word is accepted only in the same cycle as a memory write handshake (`mem_req`, `mem_we` and `mem_ready` all high), and each accepted word gives exactly one write. When `mem_ready` is low, the stream is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register index (0 command, 5 first table) |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory request; taken in a cycle where `mem_ready` is high |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | PN_W+log2(PAGE_WORDS) | Word address: page number above word index |
| mem_wdata | output | WORD_W | Write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid (one read outstanding at most) |
| mem_rdata | input | WORD_W | Read data |
| in_valid | input | 1 | Capture word valid |
| in_data | input | WORD_W | Capture word |
| in_ready | output | 1 | Capture word accepted this cycle |

## Verification
The bench feeds counting words, zero words at buffer ends and a word that already has the top bit set. These patterns separate a correct marker force from a marker that replaces the data or is missing. It lets the stream run past the end of a table both with and without a spare credit, which shows whether credits gate table entry and whether the ring link is followed. A stop that arrives in the middle of a buffer, a start followed by a stale start while running, and a clear placed between added credits show whether the controls take effect or are ignored as required. Memory ready is randomly throttled throughout, so a dropped or repeated word shows up as an address or data mismatch in the scoreboard.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
   localparam logic [31:0] CMD_CLR_CREDIT = 32'h0000_0010;
   localparam logic [31:0] CMD_ADD_CREDIT = 32'h0000_0020;
   localparam logic [31:0] CMD_START      = 32'h0c00_0040;
   localparam logic [31:0] CMD_STOP       = 32'h0808_0000;
   localparam int          REG_CTRL       = 0;
   localparam int          REG_FIRST      = 5;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CREDIT,
      ST_LINK_RQ,
      ST_LINK_WT,
      ST_SLOT_RQ,
      ST_SLOT_WT,
      ST_FILL
   } walk_state_t;
endpackage

// File: rtl/ptw_cmd_decode.sv
module ptw_cmd_decode #(
   parameter int PN_W = 32,
   parameter int RA_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_wr,
   input  logic [RA_W-1:0] reg_addr,
   input  logic [31:0]     reg_wdata,
   output logic [PN_W-1:0] first_pn,
   output logic            cmd_start,
   output logic            cmd_stop,
   output logic            cmd_clr,
   output logic            cmd_add
);
   import ptw_pkg::*;

   if (PN_W > 32) begin : g_bad_pn
      $error("PN_W must fit in a register word");
   end
   if ((1 << RA_W) <= REG_FIRST) begin : g_bad_ra
      $error("RA_W too small to reach the first-table register");
   end

   logic ctrl_wr;
   logic first_wr;

   assign ctrl_wr  = reg_wr && (reg_addr == RA_W'(REG_CTRL));
   assign first_wr = reg_wr && (reg_addr == RA_W'(REG_FIRST));

   assign cmd_start = ctrl_wr && (reg_wdata == CMD_START);
   assign cmd_stop  = ctrl_wr && (reg_wdata == CMD_STOP);
   assign cmd_clr   = ctrl_wr && (reg_wdata == CMD_CLR_CREDIT);
   assign cmd_add   = ctrl_wr && (reg_wdata == CMD_ADD_CREDIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         first_pn <= '0;
      end else if (first_wr) begin
         first_pn <= reg_wdata[PN_W-1:0];
      end
   end
endmodule

// File: rtl/ptw_credit.sv
module ptw_credit #(
   parameter int CREDIT_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                add,
   input  logic                take,
   output logic                credit_nz,
   output logic [CREDIT_W-1:0] credit_cnt
);
   localparam logic [CREDIT_W-1:0] CNT_MAX = {CREDIT_W{1'b1}};

   if (CREDIT_W < 1) begin : g_bad_w
      $error("CREDIT_W must be at least 1");
   end

   assign credit_nz = (credit_cnt != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         credit_cnt <= '0;
      end else if (clr) begin
         credit_cnt <= '0;
      end else if (add && !take) begin
         if (credit_cnt != CNT_MAX) begin
            credit_cnt <= credit_cnt + 1'b1;
         end
      end else if (take && !add) begin
         credit_cnt <= credit_cnt - 1'b1;
      end
   end
endmodule

// File: rtl/ptw_sequencer.sv
module ptw_sequencer #(
   parameter int PN_W       = 32,
   parameter int WORD_W     = 32,
   parameter int PAGE_WORDS = 1024,
   parameter int BUFS       = 511,
   parameter int IDX_W      = $clog2(PAGE_WORDS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic                  stop,
   input  logic [PN_W-1:0]       first_pn,
   input  logic                  credit_nz,
   output logic                  take,
   output logic                  busy,
   output logic                  mem_req,
   output logic                  mem_we,
   output logic [PN_W+IDX_W-1:0] mem_addr,
   input  logic                  mem_ready,
   input  logic                  mem_rvalid,
   input  logic [WORD_W-1:0]     mem_rdata,
   input  logic                  in_valid,
   output logic                  in_ready,
   output logic                  last_word
);
   import ptw_pkg::*;

   localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(BUFS);
   localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(PAGE_WORDS - 1);

   if ((1 << IDX_W) != PAGE_WORDS) begin : g_bad_page
      $error("PAGE_WORDS must be a power of two");
   end
   if (BUFS < 1 || BUFS >= PAGE_WORDS) begin : g_bad_bufs
      $error("BUFS must lie in 1 .. PAGE_WORDS-1");
   end
   if (PN_W > WORD_W) begin : g_bad_word
      $error("a page number must fit in one memory word");
   end

   walk_state_t      state;
   logic [PN_W-1:0]  table_pn;
   logic [PN_W-1:0]  next_pn;
   logic [PN_W-1:0]  buf_pn;
   logic [IDX_W-1:0] slot;
   logic [IDX_W-1:0] widx;
   logic             stop_pend;
   logic             stop_now;
   logic             waiting;
   logic             wr_fire;

   assign stop_now  = stop || stop_pend;
   assign waiting   = (state == ST_LINK_WT) || (state == ST_SLOT_WT);
   assign busy      = (state != ST_IDLE);
   assign last_word = (widx == LAST_IDX);
   assign take      = (state == ST_CREDIT) && credit_nz && !stop_now;
   assign mem_we    = (state == ST_FILL);
   assign in_ready  = (state == ST_FILL) && mem_ready && !stop_now;
   assign wr_fire   = in_valid && in_ready;

   always_comb begin
      mem_req  = 1'b0;
      mem_addr = {buf_pn, widx};
      unique case (state)
         ST_LINK_RQ: begin
            mem_req  = !stop_now;
            mem_addr = {table_pn, {IDX_W{1'b0}}};
         end
         ST_SLOT_RQ: begin
            mem_req  = !stop_now;
            mem_addr = {table_pn, slot};
         end
         ST_FILL: begin
            mem_req  = in_valid && !stop_now;
         end
         default: begin
            mem_req  = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         table_pn  <= '0;
         next_pn   <= '0;
         buf_pn    <= '0;
         slot      <= '0;
         widx      <= '0;
         stop_pend <= 1'b0;
      end else begin
         if (state == ST_IDLE) begin
            stop_pend <= 1'b0;
         end else if (stop && waiting) begin
            stop_pend <= 1'b1;
         end
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  table_pn <= first_pn;
                  state    <= ST_CREDIT;
               end
            end
            ST_CREDIT: begin
               if (stop_now) begin
                  state <= ST_IDLE;
               end else if (credit_nz) begin
                  state <= ST_LINK_RQ;
               end
            end
            ST_LINK_RQ: begin
               if (stop_now) begin
                  state <= ST_IDLE;
               end else if (mem_ready) begin
                  state <= ST_LINK_WT;
               end
            end
            ST_LINK_WT: begin
               if (mem_rvalid) begin
                  next_pn <= mem_rdata[PN_W-1:0];
                  slot    <= IDX_W'(1);
                  state   <= stop_now ? ST_IDLE : ST_SLOT_RQ;
               end
            end
            ST_SLOT_RQ: begin
               if (stop_now) begin
                  state <= ST_IDLE;
               end else if (mem_ready) begin
                  state <= ST_SLOT_WT;
               end
            end
            ST_SLOT_WT: begin
               if (mem_rvalid) begin
                  buf_pn <= mem_rdata[PN_W-1:0];
                  widx   <= '0;
                  state  <= stop_now ? ST_IDLE : ST_FILL;
               end
            end
            ST_FILL: begin
               if (stop_now) begin
                  state <= ST_IDLE;
               end else if (wr_fire) begin
                  if (last_word) begin
                     widx <= '0;
                     if (slot == LAST_SLOT) begin
                        table_pn <= next_pn;
                        state    <= ST_CREDIT;
                     end else begin
                        slot  <= slot + 1'b1;
                        state <= ST_SLOT_RQ;
                     end
                  end else begin
                     widx <= widx + 1'b1;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
   parameter int PN_W       = 32,
   parameter int WORD_W     = 32,
   parameter int PAGE_WORDS = 1024,
   parameter int BUFS       = 511,
   parameter int CREDIT_W   = 8,
   parameter int RA_W       = 3,
   parameter int MARK_BIT   = 31,
   parameter int MARK_MODE  = 0
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                reg_wr,
   input  logic [RA_W-1:0]                     reg_addr,
   input  logic [31:0]                         reg_wdata,
   output logic                                mem_req,
   output logic                                mem_we,
   output logic [PN_W+$clog2(PAGE_WORDS)-1:0]  mem_addr,
   output logic [WORD_W-1:0]                   mem_wdata,
   input  logic                                mem_ready,
   input  logic                                mem_rvalid,
   input  logic [WORD_W-1:0]                   mem_rdata,
   input  logic                                in_valid,
   input  logic [WORD_W-1:0]                   in_data,
   output logic                                in_ready
);
   localparam int IDX_W = $clog2(PAGE_WORDS);
   localparam logic [WORD_W-1:0] MARK = WORD_W'(1) << MARK_BIT;

   if (MARK_BIT < 0 || MARK_BIT >= WORD_W) begin : g_bad_mark
      $error("MARK_BIT outside the data word");
   end
   if (MARK_MODE != 0 && MARK_MODE != 1) begin : g_bad_mode
      $error("MARK_MODE must be 0 or 1");
   end

   logic [PN_W-1:0]     first_pn;
   logic                cmd_start;
   logic                cmd_stop;
   logic                cmd_clr;
   logic                cmd_add;
   logic                credit_nz;
   logic [CREDIT_W-1:0] credit_cnt;
   logic                take;
   logic                busy;
   logic                last_word;

   ptw_cmd_decode #(.PN_W(PN_W), .RA_W(RA_W)) u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .first_pn  (first_pn),
      .cmd_start (cmd_start),
      .cmd_stop  (cmd_stop),
      .cmd_clr   (cmd_clr),
      .cmd_add   (cmd_add)
   );

   ptw_credit #(.CREDIT_W(CREDIT_W)) u_credit (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (cmd_clr),
      .add        (cmd_add),
      .take       (take),
      .credit_nz  (credit_nz),
      .credit_cnt (credit_cnt)
   );

   ptw_sequencer #(
      .PN_W(PN_W), .WORD_W(WORD_W), .PAGE_WORDS(PAGE_WORDS),
      .BUFS(BUFS), .IDX_W(IDX_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (cmd_start),
      .stop       (cmd_stop),
      .first_pn   (first_pn),
      .credit_nz  (credit_nz),
      .take       (take),
      .busy       (busy),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_ready  (mem_ready),
      .mem_rvalid (mem_rvalid),
      .mem_rdata  (mem_rdata),
      .in_valid   (in_valid),
      .in_ready   (in_ready),
      .last_word  (last_word)
   );

   if (MARK_MODE == 0) begin : g_mark_or
      assign mem_wdata = last_word ? (in_data | MARK) : in_data;
   end else begin : g_mark_zero
      assign mem_wdata = (last_word && in_data == '0) ? MARK : in_data;
   end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
   parameter int AW         = 42,
   parameter int WORD_W     = 32,
   parameter int IDX_W      = 10,
   parameter int PAGE_WORDS = 1024,
   parameter int CREDIT_W   = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                busy,
   input logic                mem_req,
   input logic                mem_we,
   input logic [AW-1:0]       mem_addr,
   input logic [WORD_W-1:0]   mem_wdata,
   input logic                mem_ready,
   input logic                in_valid,
   input logic                in_ready,
   input logic                take,
   input logic                credit_nz,
   input logic [CREDIT_W-1:0] credit_cnt,
   input logic                cmd_add,
   input logic                cmd_clr,
   input logic                cmd_stop
);
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_req && !in_ready)); // R1

   AST_LAST_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_addr[IDX_W-1:0] == IDX_W'(PAGE_WORDS - 1))
      |-> (mem_wdata != '0)); // R4

   AST_CREDIT_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> credit_nz); // R5

   AST_CREDIT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !cmd_add && !cmd_clr) |=> (credit_cnt == $past(credit_cnt) - 1'b1)); // R5

   AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stop |=> !in_ready); // R8

   AST_STREAM_WRITE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) == (mem_req && mem_we && mem_ready)); // R9

   AST_READY_NEEDS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> mem_ready); // R9
endmodule

bind ptw_walker ptw_walker_chk #(
   .AW(PN_W + IDX_W), .WORD_W(WORD_W), .IDX_W(IDX_W),
   .PAGE_WORDS(PAGE_WORDS), .CREDIT_W(CREDIT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy),
   .mem_req    (mem_req),
   .mem_we     (mem_we),
   .mem_addr   (mem_addr),
   .mem_wdata  (mem_wdata),
   .mem_ready  (mem_ready),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .take       (take),
   .credit_nz  (credit_nz),
   .credit_cnt (credit_cnt),
   .cmd_add    (cmd_add),
   .cmd_clr    (cmd_clr),
   .cmd_stop   (cmd_stop)
);

// File: tb/sim_ptw_walker.sv
module sim_ptw_walker;
   localparam int PW = 8;
   localparam int NB = 3;
   localparam int IW = 3;
   localparam int AW = 32 + IW;
   localparam logic [31:0] C_CLR   = 32'h0000_0010;
   localparam logic [31:0] C_ADD   = 32'h0000_0020;
   localparam logic [31:0] C_START = 32'h0c00_0040;
   localparam logic [31:0] C_STOP  = 32'h0808_0000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [2:0]    reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic          mem_req, mem_we, in_ready;
   logic [AW-1:0] mem_addr;
   logic [31:0]   mem_wdata;
   logic          mem_ready = 1'b0;
   logic          mem_rvalid = 1'b0;
   logic [31:0]   mem_rdata = '0;
   logic          in_valid = 1'b0;
   logic [31:0]   in_data = '0;

   always #5 clk = ~clk;

   ptw_walker #(.PAGE_WORDS(PW), .BUFS(NB)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .in_valid(in_valid),
      .in_data(in_data), .in_ready(in_ready)
   );

   int          n_tests = 0;
   int          n_fail = 0;
   bit          done = 1'b0;
   logic [31:0] stream_q[$];
   logic [AW-1:0] exp_a[$];
   logic [31:0] exp_d[$];
   int          wr_cnt = 0;
   int          txn_cnt = 0;
   int          m_tab = 0, m_slot = 0, m_w = 0;

   function automatic logic [31:0] tab_pn(int t);
      return 32'h100 * (t + 1);
   endfunction

   function automatic logic [31:0] buf_pn(int t, int s);
      return 32'h40 + 16 * t + s;
   endfunction

   function automatic logic [31:0] mem_model(logic [AW-1:0] a);
      logic [31:0] pn;
      int idx;
      pn  = a[AW-1:IW];
      idx = int'(a[IW-1:0]);
      for (int t = 0; t < 2; t++) begin
         if (pn == tab_pn(t)) begin
            if (idx == 0) return tab_pn(1 - t);
            if (idx <= NB) return buf_pn(t, idx - 1);
         end
      end
      return 32'hdead_0000;
   endfunction

   task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual %h expected %h", req, act, expv);
      end
   endtask

   // driver: a stream word plus its expected write, from the walk model
   task automatic push_word(logic [31:0] d);
      stream_q.push_back(d);
      exp_a.push_back({buf_pn(m_tab, m_slot), IW'(m_w)});
      exp_d.push_back((m_w == PW - 1) ? (d | 32'h8000_0000) : d);
      m_w++;
      if (m_w == PW) begin
         m_w = 0;
         m_slot++;
         if (m_slot == NB) begin
            m_slot = 0;
            m_tab = (m_tab + 1) % 2;
         end
      end
   endtask

   task automatic reg_write(logic [2:0] a, logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1;
      reg_addr = a;
      reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic wait_drain();
      while (exp_a.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   // bus process: stream source, memory model, write monitor
   initial begin
      bit s_acc;
      int rd_wait;
      logic [AW-1:0] rd_addr;
      logic [AW-1:0] ea;
      logic [31:0] ed;
      s_acc = 1'b0;
      rd_wait = 0;
      rd_addr = '0;
      forever begin
         @(negedge clk);
         if (s_acc) begin
            void'(stream_q.pop_front());
            in_valid = 1'b0;
         end
         if (!in_valid && stream_q.size() > 0 && ($urandom % 4) != 0) begin
            in_valid = 1'b1;
            in_data = stream_q[0];
         end
         mem_ready = (($urandom % 10) < 7);
         mem_rvalid = 1'b0;
         if (rd_wait > 0) begin
            rd_wait--;
            if (rd_wait == 0) begin
               mem_rvalid = 1'b1;
               mem_rdata = mem_model(rd_addr);
            end
         end
         #3;
         s_acc = in_valid && in_ready;
         if (mem_req && mem_ready) begin
            txn_cnt++;
            if (mem_we) begin
               wr_cnt++;
               if (exp_a.size() == 0) begin
                  check(1'b0, "R9 unexpected write", 64'(mem_addr), 64'(0));
               end else begin
                  ea = exp_a.pop_front();
                  ed = exp_d.pop_front();
                  check(mem_addr == ea, "R2 R3 write address", 64'(mem_addr), 64'(ea));
                  check(mem_wdata == ed, "R4 R9 write data", 64'(mem_wdata), 64'(ed));
               end
            end else begin
               check((mem_addr[AW-1:IW] == tab_pn(0) || mem_addr[AW-1:IW] == tab_pn(1))
                     && mem_addr[IW-1:0] <= IW'(NB),
                     "R2 read target", 64'(mem_addr), 64'(tab_pn(m_tab)));
               rd_addr = mem_addr;
               rd_wait = 2;
            end
         end
      end
   end

   initial begin
      int t0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #3;
      check(!mem_req && !in_ready, "R1 reset quiet", {62'b0, mem_req, in_ready}, 64'(0));

      // zero credits: start must not touch memory; a stray command adds nothing
      reg_write(3'd5, tab_pn(0));
      reg_write(3'd0, C_CLR);
      reg_write(3'd0, 32'h0000_0030);
      reg_write(3'd0, C_START);
      for (int k = 0; k < 2 * NB * PW; k++) begin
         if (k == 7 || k == 15) push_word(32'h0);
         else if (k == 23) push_word(32'h8000_00aa);
         else push_word(32'h0100_0000 + k);
      end
      t0 = txn_cnt;
      repeat (20) @(negedge clk);
      #3;
      check(txn_cnt == t0, "R5 R6 R7 no traffic without credit", 64'(txn_cnt), 64'(t0));
      check(!in_ready, "R5 stream held without credit", 64'(in_ready), 64'(0));

      // two credits: two full tables
      reg_write(3'd0, C_ADD);
      reg_write(3'd0, C_ADD);
      wait_drain();
      check(wr_cnt == 2 * NB * PW, "R2 two tables written", 64'(wr_cnt), 64'(2 * NB * PW));

      // credits used up at table end: walker waits
      push_word(32'h0200_0000);
      t0 = wr_cnt;
      repeat (20) @(negedge clk);
      #3;
      check(wr_cnt == t0, "R5 stall at table end", 64'(wr_cnt), 64'(t0));
      check(in_valid && !in_ready, "R9 word held during stall",
            {62'b0, in_valid, in_ready}, 64'(2));

      // one more credit: ring back to first table
      reg_write(3'd0, C_ADD);
      for (int k = 1; k < 4; k++) push_word(32'h0200_0000 + k);
      wait_drain();
      check(wr_cnt == 2 * NB * PW + 4, "R3 ring return", 64'(wr_cnt), 64'(2 * NB * PW + 4));

      // stop in the middle of a buffer
      reg_write(3'd0, C_STOP);
      m_tab = 1; m_slot = 0; m_w = 0;
      push_word(32'h0300_0000);
      t0 = wr_cnt;
      repeat (20) @(negedge clk);
      #3;
      check(wr_cnt == t0 && !in_ready, "R8 no writes after stop", 64'(wr_cnt), 64'(t0));

      // credits: add, add, clear, add leaves exactly one
      reg_write(3'd0, C_ADD);
      reg_write(3'd0, C_ADD);
      reg_write(3'd0, C_CLR);
      reg_write(3'd0, C_ADD);
      reg_write(3'd5, tab_pn(1));
      reg_write(3'd0, C_START);
      for (int k = 1; k < 6; k++) push_word(32'h0300_0000 + k);
      reg_write(3'd5, 32'h0000_0777);
      reg_write(3'd0, C_START);   // R7: ignored while running
      for (int k = 6; k < NB * PW; k++) push_word(32'h0300_0000 + k);
      wait_drain();
      check(wr_cnt == 2 * NB * PW + 4 + NB * PW, "R7 restart at second table",
            64'(wr_cnt), 64'(3 * NB * PW + 4));

      push_word(32'h0400_0000);
      t0 = wr_cnt;
      repeat (20) @(negedge clk);
      #3;
      check(wr_cnt == t0, "R6 clear left one credit", 64'(wr_cnt), 64'(t0));

      reg_write(3'd0, C_ADD);
      wait_drain();
      check(exp_a.size() == 0 && wr_cnt == t0 + 1, "R3 link from second table",
            64'(wr_cnt), 64'(t0 + 1));

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired, R9 progress actual stalled expected done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule